// File: doc/BRIEF.md
# HDLC Timeslot Byte Source

This block feeds the receive-side TDM stream with one byte per HDLC channel in every frame. A packet producer hands over finished packets by pushing descriptors into a small circular queue kept for each channel. A descriptor names the channel the packet came from, where the packet starts in a buffer memory, and how many bytes it holds. On each frame the block walks through the channels in ascending order. For each channel it either fetches the next packet byte from the buffer or, when there is no packet to send, emits an idle fill byte whose value depends on that channel's HDLC mode.

A pulse on `frameStart` begins a frame walk. The walk services channel 0 in the following cycle, then each higher channel in turn, one per cycle. The buffer is read through a synchronous port: the address goes out in the service cycle, and the returned byte is presented on the slot outputs one cycle later. A descriptor is taken from a queue only at a packet boundary. When the running packet is on its last byte, the next descriptor is taken at once, so queued packets follow one another with no idle byte between them.

Top module: `hdlc_slot_source`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `slotValid` and `pushOverflow` are 0. Every queue starts empty, so the first frame after reset yields only idle fill.
- R2: A `frameStart` pulse sampled at clock edge E yields exactly NUM_CH slot cycles. These follow edges E+1 to E+NUM_CH, and `slotChan` rises 0, 1, … NUM_CH-1. `slotValid` is 0 again after edge E+NUM_CH+1 unless a new frame was started.
- R3: An idle slot has `slotIsData`=0. Its `slotByte` is FFh when `byteMode` of that channel is 0 (bit-wise) and 7Eh when it is 1 (byte-wise). The mode is sampled in the channel's service cycle.
- R4: Each channel queue holds at most DEPTH (16) descriptors. A push into a full queue is refused, and `pushOverflow` is 1 in the cycle after that push. A refused descriptor is never emitted.
- R5: When a channel with no packet in progress takes a descriptor, the slot for that frame is still idle fill. The packet's first byte comes out when the channel is next serviced.
- R6: A data slot has `slotIsData`=1 and a `slotByte` equal to the buffer byte at address base+offset. The offset runs 0 … len-1 over successive frames, and the sum wraps modulo 2^ADDR_W. The buffer data is taken one cycle after the `bufRdEn`/`bufAddr` cycle. Descriptor length is at least 1.
- R7: If a channel's queue is non-empty when it emits a packet's last byte, it takes the next descriptor in that service cycle. The next frame then emits that packet's first byte, with no idle slot in between.
- R8: If the queue is empty when a packet's last byte is emitted, that channel emits idle fill from the next frame until a descriptor arrives.
- R9: Each channel sends descriptors in push order, and queues of different channels do not affect each other. A data slot shows the descriptor's origin field on `slotOrigin`. An idle slot shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteMode | input | NUM_CH | Per-channel HDLC mode, 1 = byte-wise, 0 = bit-wise |
| pushValid | input | 1 | Push a descriptor this cycle |
| pushChan | input | CH_W | Queue (channel) receiving the descriptor |
| pushOrigin | input | ORIG_W | Origin channel number carried by the descriptor |
| pushBase | input | ADDR_W | Packet base address in the buffer |
| pushLen | input | LEN_W | Packet length in bytes (at least 1) |
| pushOverflow | output | 1 | Previous-cycle push was refused because the queue was full |
| frameStart | input | 1 | Starts one frame walk over all channels |
| bufRdEn | output | 1 | Buffer read request |
| bufAddr | output | ADDR_W | Buffer read address |
| bufRdData | input | 8 | Buffer byte, valid one cycle after the request |
| slotValid | output | 1 | A slot byte is presented |
| slotChan | output | CH_W | Channel of the presented slot |
| slotIsData | output | 1 | 1 for a packet byte, 0 for idle fill |
| slotByte | output | 8 | Byte for the timeslot |
| slotOrigin | output | ORIG_W | Origin field of the packet being sent, 0 when idle |

## Verification
The bench builds the block with its defaults: four channels, a queue depth of 16, 12-bit buffer addresses and 8-bit lengths. With four channels a frame walk is five cycles long, so thousands of slots can be checked in a short run. A depth of 16 is filled and overrun in seventeen pushes, which reaches the refusal path. With 12-bit addresses a base of FFEh reaches the wrap of base+offset back to address 0. Random pushes of short packets, mixed with random per-channel modes, often make a channel hit its last byte while more descriptors are waiting. This drives the chained-pop path as well as the pop from an idle channel.

// File: rtl/hdlc_slot_pkg.sv
package hdlc_slot_pkg;

  // Strobes passed from the control to the datapath in each cycle.
  typedef struct packed {
    logic wrEn;     // store pushed descriptor
    logic svc;      // a channel is being serviced this cycle
    logic emitData; // serviced channel sends a packet byte
    logic pop;      // serviced channel loads its next descriptor
  } ctlStrobe_t;

  localparam logic [7:0] FILL_BITWISE  = 8'hFF;
  localparam logic [7:0] FILL_BYTEWISE = 8'h7E;

  function automatic logic [7:0] idleFill(input logic byteWise);
    return byteWise ? FILL_BYTEWISE : FILL_BITWISE;
  endfunction

endpackage

// File: rtl/hdlc_slot_ctrl.sv
module hdlc_slot_ctrl
  import hdlc_slot_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStart,
  input  logic             pushValid,
  input  logic [CH_W-1:0]  pushChan,
  input  logic             remZero,
  input  logic             remOne,
  output ctlStrobe_t       stb,
  output logic [CH_W-1:0]  svcCh,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] popIdx,
  output logic             pushOverflow
);

  logic [PTR_W-1:0] wrPtr [NUM_CH];
  logic [PTR_W-1:0] rdPtr [NUM_CH];
  logic [NUM_CH-1:0] qEmpty;
  logic [NUM_CH-1:0] qFull;
  logic active;
  logic pushOk;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_qstat
    assign qEmpty[c] = (wrPtr[c] == rdPtr[c]);
    assign qFull[c]  = ((wrPtr[c] - rdPtr[c]) == PTR_W'(DEPTH));

    // R4: occupancy never exceeds the queue depth
    a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (wrPtr[c] - rdPtr[c]) <= PTR_W'(DEPTH));
  end

  assign pushOk = pushValid && !qFull[pushChan];

  always_comb begin
    stb.wrEn     = pushOk;
    stb.svc      = active;
    stb.emitData = active && !remZero;
    stb.pop      = active && !qEmpty[svcCh] && (remZero || remOne);
  end

  assign wrIdx  = wrPtr[pushChan][IDX_W-1:0];
  assign popIdx = rdPtr[svcCh][IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        wrPtr[c] <= '0;
        rdPtr[c] <= '0;
      end
      pushOverflow <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (pushOk && pushChan == CH_W'(c)) wrPtr[c] <= wrPtr[c] + 1'b1;
        if (stb.pop && svcCh == CH_W'(c))   rdPtr[c] <= rdPtr[c] + 1'b1;
      end
      pushOverflow <= pushValid && qFull[pushChan];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      svcCh  <= '0;
    end else if (frameStart) begin
      active <= 1'b1;
      svcCh  <= '0;
    end else if (active) begin
      if (svcCh == CH_W'(NUM_CH - 1)) active <= 1'b0;
      else                            svcCh  <= svcCh + 1'b1;
    end
  end

  // R4: a refusal is only reported for a push made one cycle earlier
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pushOverflow |-> $past(pushValid));

  // R2: channels are walked in ascending order, one per cycle
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frameStart && svcCh != CH_W'(NUM_CH - 1))
      |=> (active && svcCh == $past(svcCh) + 1'b1));

endmodule

// File: rtl/hdlc_slot_dpath.sv
module hdlc_slot_dpath
  import hdlc_slot_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 16,
  parameter int ORIG_W = 10,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        stb,
  input  logic [CH_W-1:0]   svcCh,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  popIdx,
  input  logic [CH_W-1:0]   pushChan,
  input  logic [ORIG_W-1:0] pushOrigin,
  input  logic [ADDR_W-1:0] pushBase,
  input  logic [LEN_W-1:0]  pushLen,
  input  logic [NUM_CH-1:0] byteMode,
  output logic              remZero,
  output logic              remOne,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufRdData,
  output logic              slotValid,
  output logic [CH_W-1:0]   slotChan,
  output logic              slotIsData,
  output logic [7:0]        slotByte,
  output logic [ORIG_W-1:0] slotOrigin
);

  localparam int DESC_W = ORIG_W + ADDR_W + LEN_W;
  localparam int RAM_N  = NUM_CH * DEPTH;

  logic [DESC_W-1:0] descRam [RAM_N];
  logic [DESC_W-1:0] popDesc;
  logic [ORIG_W-1:0] popOrig;
  logic [ADDR_W-1:0] popBase;
  logic [LEN_W-1:0]  popLen;

  logic [ADDR_W-1:0] baseR [NUM_CH];
  logic [LEN_W-1:0]  offR  [NUM_CH];
  logic [LEN_W-1:0]  remR  [NUM_CH];
  logic [ORIG_W-1:0] origR [NUM_CH];
  logic [7:0]        fillR;

  always_ff @(posedge clk) begin
    if (stb.wrEn) descRam[{pushChan, wrIdx}] <= {pushOrigin, pushBase, pushLen};
  end

  assign popDesc = descRam[{svcCh, popIdx}];
  assign {popOrig, popBase, popLen} = popDesc;

  assign remZero = (remR[svcCh] == '0);
  assign remOne  = (remR[svcCh] == LEN_W'(1));
  assign bufRdEn = stb.emitData;
  assign bufAddr = baseR[svcCh] + ADDR_W'(offR[svcCh]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        baseR[c] <= '0;
        offR[c]  <= '0;
        remR[c]  <= '0;
        origR[c] <= '0;
      end
    end else if (stb.svc) begin
      if (stb.emitData) begin
        offR[svcCh] <= offR[svcCh] + 1'b1;
        remR[svcCh] <= remR[svcCh] - 1'b1;
      end
      if (stb.pop) begin
        baseR[svcCh] <= popBase;
        offR[svcCh]  <= '0;
        remR[svcCh]  <= popLen;
        origR[svcCh] <= popOrig;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotValid  <= 1'b0;
      slotChan   <= '0;
      slotIsData <= 1'b0;
      slotOrigin <= '0;
      fillR      <= FILL_BITWISE;
    end else begin
      slotValid  <= stb.svc;
      slotChan   <= svcCh;
      slotIsData <= stb.svc && stb.emitData;
      slotOrigin <= (stb.svc && stb.emitData) ? origR[svcCh] : '0;
      fillR      <= idleFill(byteMode[svcCh]);
    end
  end

  assign slotByte = slotIsData ? bufRdData : fillR;

  // R6: every buffer read turns into a data slot on the next cycle
  a_r6_read_to_slot: assert property (@(posedge clk) disable iff (!rst_n)
    bufRdEn |=> (slotValid && slotIsData));

  // R3: idle slots carry one of the two fill codes
  a_r3_fill_value: assert property (@(posedge clk) disable iff (!rst_n)
    (slotValid && !slotIsData) |-> (slotByte == FILL_BITWISE || slotByte == FILL_BYTEWISE));

  // R5: loading a packet into an idle channel gives an idle slot that frame
  a_r5_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.pop && remZero) |=> (slotValid && !slotIsData));

  // R9: idle slots show a zero origin
  a_r9_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (slotValid && !slotIsData) |-> (slotOrigin == '0));

endmodule

// File: rtl/hdlc_slot_source.sv
module hdlc_slot_source
  import hdlc_slot_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 16,
  parameter int ORIG_W = 10,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] byteMode,
  input  logic              pushValid,
  input  logic [CH_W-1:0]   pushChan,
  input  logic [ORIG_W-1:0] pushOrigin,
  input  logic [ADDR_W-1:0] pushBase,
  input  logic [LEN_W-1:0]  pushLen,
  output logic              pushOverflow,
  input  logic              frameStart,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufRdData,
  output logic              slotValid,
  output logic [CH_W-1:0]   slotChan,
  output logic              slotIsData,
  output logic [7:0]        slotByte,
  output logic [ORIG_W-1:0] slotOrigin
);

  localparam int IDX_W = $clog2(DEPTH);

  ctlStrobe_t       stb;
  logic [CH_W-1:0]  svcCh;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] popIdx;
  logic             remZero;
  logic             remOne;

  hdlc_slot_ctrl #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart),
    .pushValid(pushValid), .pushChan(pushChan),
    .remZero(remZero), .remOne(remOne),
    .stb(stb), .svcCh(svcCh), .wrIdx(wrIdx), .popIdx(popIdx),
    .pushOverflow(pushOverflow)
  );

  hdlc_slot_dpath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .ORIG_W(ORIG_W),
                    .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .svcCh(svcCh),
    .wrIdx(wrIdx), .popIdx(popIdx), .pushChan(pushChan),
    .pushOrigin(pushOrigin), .pushBase(pushBase), .pushLen(pushLen),
    .byteMode(byteMode), .remZero(remZero), .remOne(remOne),
    .bufRdEn(bufRdEn), .bufAddr(bufAddr), .bufRdData(bufRdData),
    .slotValid(slotValid), .slotChan(slotChan), .slotIsData(slotIsData),
    .slotByte(slotByte), .slotOrigin(slotOrigin)
  );

  // R1: no slot is presented while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!slotValid && !pushOverflow));

endmodule

// File: tb/sim_hdlc_slot_source.sv
module sim_hdlc_slot_source;
  localparam int NCH = 4;
  localparam int QD  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] byteMode = '0;
  logic pushValid = 1'b0;
  logic [1:0] pushChan = '0;
  logic [9:0] pushOrigin = '0;
  logic [11:0] pushBase = '0;
  logic [7:0] pushLen = '0;
  logic pushOverflow;
  logic frameStart = 1'b0;
  logic bufRdEn;
  logic [11:0] bufAddr;
  logic [7:0] bufRdData;
  logic slotValid;
  logic [1:0] slotChan;
  logic slotIsData;
  logic [7:0] slotByte;
  logic [9:0] slotOrigin;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  int qOrig [NCH][QD];
  int qBase [NCH][QD];
  int qLen  [NCH][QD];
  int qWr [NCH];
  int qRd [NCH];
  int mRem [NCH];
  int mBase [NCH];
  int mOff [NCH];
  int mOrig [NCH];
  bit mChained [NCH];
  bit mEnded [NCH];

  always #5 clk = ~clk;

  hdlc_slot_source u0 (
    .clk(clk), .rst_n(rst_n), .byteMode(byteMode),
    .pushValid(pushValid), .pushChan(pushChan), .pushOrigin(pushOrigin),
    .pushBase(pushBase), .pushLen(pushLen), .pushOverflow(pushOverflow),
    .frameStart(frameStart), .bufRdEn(bufRdEn), .bufAddr(bufAddr),
    .bufRdData(bufRdData), .slotValid(slotValid), .slotChan(slotChan),
    .slotIsData(slotIsData), .slotByte(slotByte), .slotOrigin(slotOrigin)
  );

  function automatic logic [7:0] memFn(input logic [11:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd29;
    return p ^ {4'h0, a[11:8]} ^ 8'h5A;
  endfunction

  // synchronous buffer model: one cycle read latency
  always_ff @(posedge clk) if (bufRdEn) bufRdData <= memFn(bufAddr);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doPush(input int ch, input int orig, input int base, input int len);
    bit expOvf;
    expOvf = (qWr[ch] - qRd[ch]) == QD;
    if (!expOvf) begin
      qOrig[ch][qWr[ch] % QD] = orig;
      qBase[ch][qWr[ch] % QD] = base;
      qLen[ch][qWr[ch] % QD]  = len;
      qWr[ch]++;
    end
    pushValid = 1'b1; pushChan = 2'(ch); pushOrigin = 10'(orig);
    pushBase = 12'(base); pushLen = 8'(len);
    @(negedge clk);
    pushValid = 1'b0;
    chk(pushOverflow == expOvf, "R4", "pushOverflow", int'(pushOverflow), int'(expOvf));
  endtask

  task automatic runFrame();
    int rem, expB, expO, addr, s;
    bit expD;
    string tag;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      @(negedge clk);
      rem = mRem[k];
      expD = 0; expO = 0;
      expB = byteMode[k] ? 'h7E : 'hFF;
      tag = mEnded[k] ? "R8" : "R3";
      if (rem > 0) begin
        expD = 1;
        addr = (mBase[k] + mOff[k]) & 'hFFF;
        expB = int'(memFn(12'(addr)));
        expO = mOrig[k];
        tag = mChained[k] ? "R7" : "R6";
        mChained[k] = 0;
        mOff[k]++;
        mRem[k]--;
        if (mRem[k] == 0) mEnded[k] = 1;
      end
      if ((qWr[k] - qRd[k]) > 0 && rem <= 1) begin
        if (rem == 0) tag = "R5";
        s = qRd[k] % QD;
        mBase[k] = qBase[k][s]; mOff[k] = 0; mRem[k] = qLen[k][s]; mOrig[k] = qOrig[k][s];
        qRd[k]++;
        mEnded[k] = 0;
        mChained[k] = (rem == 1);
      end
      chk(slotValid == 1'b1, "R2", "slotValid", int'(slotValid), 1);
      chk(int'(slotChan) == k, "R2", "slotChan", int'(slotChan), k);
      chk(slotIsData == expD, tag, "slotIsData", int'(slotIsData), int'(expD));
      chk(int'(slotByte) == expB, tag, "slotByte", int'(slotByte), expB);
      chk(int'(slotOrigin) == expO, "R9", "slotOrigin", int'(slotOrigin), expO);
    end
    @(negedge clk);
    chk(slotValid == 1'b0, "R2", "slotValid after walk", int'(slotValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    for (int c = 0; c < NCH; c++) begin
      qWr[c] = 0; qRd[c] = 0; mRem[c] = 0; mBase[c] = 0; mOff[c] = 0;
      mOrig[c] = 0; mChained[c] = 0; mEnded[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk(slotValid == 1'b0, "R1", "slotValid in reset", int'(slotValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slotValid == 1'b0, "R1", "slotValid after reset", int'(slotValid), 0);
    chk(pushOverflow == 1'b0, "R1", "pushOverflow after reset", int'(pushOverflow), 0);

    // R1/R3: empty queues give fill; mixed modes
    byteMode = 4'b0101;
    runFrame();
    byteMode = 4'b1010;
    runFrame();

    // R4: overrun channel 2, then drain it (R9 ordering)
    for (int i = 0; i < QD + 1; i++) doPush(2, 100 + i, 16 * i, 2);
    // R7/R8: two back-to-back packets on channel 1
    doPush(1, 7, 12'h300, 2);
    doPush(1, 8, 12'h340, 3);
    // R6: address wrap on channel 3
    doPush(3, 9, 12'hFFE, 4);
    for (int f = 0; f < 2 * QD + 8; f++) runFrame();

    // random phase
    for (int it = 0; it < 600; it++) begin
      if (($urandom % 3) == 0) begin
        byteMode = 4'($urandom);
        runFrame();
      end else begin
        doPush(int'($urandom % NCH), int'($urandom % 1024),
               int'($urandom % 4096), 1 + int'($urandom % 5));
      end
    end
    for (int f = 0; f < 120; f++) runFrame();

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule